// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

This block drives a two-digit seven-segment display whose seven segment lines are shared by both digits and steered by one digit-select line. Each digit is given as a 5-bit character code. An internal decode function turns each code into an active-high segment pattern: hexadecimal digits, each single segment on its own, a few letter shapes, and blanks. The segment byte is ordered a (MSB) down to g (LSB).

A divider produces a one-cycle tick at twice the wanted refresh rate. Each tick flips the digit-select register, so the select is an exact 50% square wave. The select steers a 2:1 choice of the two decoded patterns onto the shared segment outputs. The segment outputs are registered, so a pattern change and a select change land on the same clock edge. In hardware, a 100 MHz clock and a 60 Hz refresh give a 120 Hz tick. The `SIMULATE` parameter replaces the divider's terminal count with a small constant, so a bench sees the digits swap every few cycles.

Top module: `ssd_mux_driver`

## Requirements
- R1: Codes 0 to 9 produce the decimal digits. As hex patterns (bit 6 = segment a, bit 0 = segment g, 1 = lit) they are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B.
- R2: Codes 10 to 15 produce A, b, C, d, E, F, which are 77, 1F, 4E, 3D, 4F, 47.
- R3: Codes 16 to 22 each light one segment only. Code 16+k produces 40 hex shifted right by k, so code 16 is segment a and code 22 is segment g.
- R4: Codes 24 to 28 produce upper H (37), upper L (0E), upper R (77, the same as A), lower l (30, the same as 1) and lower r (05).
- R5: Code 23 and codes 29 to 31 produce a blank pattern (00).
- R6: While `digit_sel` is 0, `seg_out` shows the pattern of `code_lo`. While it is 1, `seg_out` shows the pattern of `code_hi`. `seg_out` reflects the codes and the select value present at the preceding clock edge, with one register of latency.
- R7: `digit_sel` flips once every TERMINAL+1 cycles and holds between flips, which gives a 50% duty cycle. TERMINAL is `SIM_TERMINAL` (default 8) when `SIMULATE`=1, and CLK_HZ/(2·REFRESH_HZ)−1 otherwise. The first flip comes TERMINAL+1 edges after the first edge with reset low.
- R8: A synchronous, active-high `rst` forces `digit_sel` to 0 and `seg_out` to 00, and restarts the divider count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (100 MHz assumed) |
| rst | input | 1 | Synchronous active-high reset |
| code_lo | input | 5 | Character code shown while select is 0 |
| code_hi | input | 5 | Character code shown while select is 1 |
| seg_out | output | 7 | Shared segment lines, a at bit 6 to g at bit 0, active high |
| digit_sel | output | 1 | 50% duty digit-select square wave |

## Verification
The bench sweeps all 32 codes, with the two digits always carrying different codes. A design that swapped the mux legs, or decoded one digit's code for the other, then shows the wrong glyph in one select phase. It checks the phase of the select across reset release and across a reset asserted mid-period. A divider that is off by one, or that does not restart, drifts against the reference period. It also changes codes on every cycle while the select flips. A design that updated segments a cycle late or early, or out of step with the select, then shows a stale pattern on exactly those edges.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

   localparam int CODE_W = 5;
   localparam int SEG_W  = 7;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [SEG_W-1:0]  seg_t;

   // Segment byte layout: bit 6 = a ... bit 0 = g, 1 = lit.
   function automatic seg_t glyph(input code_t c);
      seg_t p;
      case (c)
         5'd0:  p = 7'h7E;
         5'd1:  p = 7'h30;
         5'd2:  p = 7'h6D;
         5'd3:  p = 7'h79;
         5'd4:  p = 7'h33;
         5'd5:  p = 7'h5B;
         5'd6:  p = 7'h5F;
         5'd7:  p = 7'h70;
         5'd8:  p = 7'h7F;
         5'd9:  p = 7'h7B;
         5'd10: p = 7'h77;
         5'd11: p = 7'h1F;
         5'd12: p = 7'h4E;
         5'd13: p = 7'h3D;
         5'd14: p = 7'h4F;
         5'd15: p = 7'h47;
         5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22:
            p = seg_t'(7'h40 >> (c - 5'd16));
         5'd24: p = 7'h37;   // H
         5'd25: p = 7'h0E;   // L
         5'd26: p = 7'h77;   // R, shares the A shape
         5'd27: p = 7'h30;   // l, shares the 1 shape
         5'd28: p = 7'h05;   // r
         default: p = '0;    // blanks: 23, 29..31
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ssd_tick_div.sv
module ssd_tick_div #(
   parameter int TERMINAL = 8
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CNT_W = (TERMINAL < 1) ? 1 : $clog2(TERMINAL + 1);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(TERMINAL);

   generate
      if (TERMINAL < 1) begin : g_bad_terminal
         $error("ssd_tick_div: TERMINAL must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == TOP);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   // A tick never lasts more than one cycle.
   assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // The count never passes the terminal value.
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= TOP);

endmodule

// File: rtl/ssd_select_gen.sv
module ssd_select_gen (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic sel_next,
   output logic sel
);
   assign sel_next = tick ? ~sel : sel;

   always_ff @(posedge clk) begin
      if (rst) sel <= 1'b0;
      else     sel <= sel_next;
   end

   // The select holds its value on every cycle without a tick.
   assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(sel));

   // The select flips on every tick.
   assert_flip_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
      tick |=> (sel != $past(sel)));

endmodule

// File: rtl/ssd_seg_mux.sv
module ssd_seg_mux
   import ssd_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  sel_next,
   input  code_t code_lo,
   input  code_t code_hi,
   output seg_t  seg
);
   localparam int DIGITS = 2;

   code_t codes [DIGITS];
   seg_t  pats  [DIGITS];

   assign codes[0] = code_lo;
   assign codes[1] = code_hi;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dec
         assign pats[i] = glyph(codes[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) seg <= '0;
      else     seg <= pats[sel_next];
   end

   code_t chosen;
   assign chosen = sel_next ? code_hi : code_lo;

   // A single-segment code lights exactly one line on the next cycle.
   assert_single_seg_R3: assert property (@(posedge clk) disable iff (rst)
      (chosen inside {[5'd16:5'd22]}) |=> ($countones(seg) == 1));

   // A blank code leaves every line dark on the next cycle.
   assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
      (chosen == 5'd23 || chosen >= 5'd29) |=> (seg == '0));

   // Digit codes never produce a dark pattern.
   assert_digit_lit_R1: assert property (@(posedge clk) disable iff (rst)
      (chosen <= 5'd9) |=> (seg != '0));

endmodule

// File: rtl/ssd_mux_driver.sv
module ssd_mux_driver
   import ssd_pkg::*;
#(
   parameter bit SIMULATE     = 1'b1,
   parameter int CLK_HZ       = 100_000_000,
   parameter int REFRESH_HZ   = 60,
   parameter int SIM_TERMINAL = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [4:0] code_lo,
   input  logic [4:0] code_hi,
   output logic [6:0] seg_out,
   output logic       digit_sel
);
   localparam int TICK_HZ     = 2 * REFRESH_HZ;
   localparam int HW_TERMINAL = CLK_HZ / TICK_HZ - 1;

   generate
      if (REFRESH_HZ <= 50) begin : g_bad_refresh
         $error("ssd_mux_driver: REFRESH_HZ must exceed 50");
      end
      if (CLK_HZ < 2 * TICK_HZ) begin : g_bad_clock
         $error("ssd_mux_driver: CLK_HZ too low for REFRESH_HZ");
      end
      if (SIM_TERMINAL < 1) begin : g_bad_sim
         $error("ssd_mux_driver: SIM_TERMINAL must be at least 1");
      end
   endgenerate

   logic tick;
   logic sel_next;
   seg_t seg_q;

   generate
      if (SIMULATE) begin : g_sim_div
         ssd_tick_div #(.TERMINAL(SIM_TERMINAL)) u_div (
            .clk  (clk),
            .rst  (rst),
            .tick (tick)
         );
      end else begin : g_hw_div
         ssd_tick_div #(.TERMINAL(HW_TERMINAL)) u_div (
            .clk  (clk),
            .rst  (rst),
            .tick (tick)
         );
      end
   endgenerate

   ssd_select_gen u_sel (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .sel_next (sel_next),
      .sel      (digit_sel)
   );

   ssd_seg_mux u_mux (
      .clk      (clk),
      .rst      (rst),
      .sel_next (sel_next),
      .code_lo  (code_lo),
      .code_hi  (code_hi),
      .seg      (seg_q)
   );

   assign seg_out = seg_q;

   // Reset leaves a dark display and a low select.
   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (seg_out == '0 && !digit_sel));

   // With both codes steady across a select flip, the outputs show the newly chosen digit.
   assert_mux_leg_R6: assert property (@(posedge clk) disable iff (rst)
      ($changed(digit_sel) && $stable(code_lo) && $stable(code_hi) && !$past(rst))
      |-> (seg_out == (digit_sel ? glyph(code_hi) : glyph(code_lo))));

endmodule

// File: tb/tb_ssd_mux_driver.sv
module tb_ssd_mux_driver;

   localparam int TERM = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] code_lo = '0;
   logic [4:0] code_hi = '0;
   logic [6:0] seg_out;
   logic       digit_sel;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   ssd_mux_driver #(.SIMULATE(1'b1), .SIM_TERMINAL(TERM)) dut (
      .clk       (clk),
      .rst       (rst),
      .code_lo   (code_lo),
      .code_hi   (code_hi),
      .seg_out   (seg_out),
      .digit_sel (digit_sel)
   );

   // Build a pattern from segment letters (a = bit 6 ... g = bit 0).
   function automatic logic [6:0] shape(input string s);
      logic [6:0] p = '0;
      for (int i = 0; i < s.len(); i++) p[6 - (s[i] - "a")] = 1'b1;
      return p;
   endfunction

   function automatic logic [6:0] ref_glyph(input int c);
      case (c)
         0: return shape("abcdef");   1: return shape("bc");
         2: return shape("abdeg");    3: return shape("abcdg");
         4: return shape("bcfg");     5: return shape("acdfg");
         6: return shape("acdefg");   7: return shape("abc");
         8: return shape("abcdefg");  9: return shape("abcdfg");
         10: return shape("abcefg");  11: return shape("cdefg");
         12: return shape("adef");    13: return shape("bcdeg");
         14: return shape("adefg");   15: return shape("aefg");
         24: return shape("bcefg");   25: return shape("def");
         26: return shape("abcefg");  27: return shape("bc");
         28: return shape("eg");
         default: begin
            if (c >= 16 && c <= 22) begin
               string one = " ";
               one[0] = byte'("a" + (c - 16));
               return shape(one);
            end
            return 7'h00;
         end
      endcase
   endfunction

   function automatic string code_req(input int c);
      if (c <= 9)              return "R1";
      if (c <= 15)             return "R2";
      if (c <= 22)             return "R3";
      if (c >= 24 && c <= 28)  return "R4";
      return "R5";
   endfunction

   // Scoreboard queues, filled by the reference model, drained by the monitor.
   logic [7:0] q_exp [$];
   string      q_seg_tag [$];
   string      q_sel_tag [$];

   int m_cnt = 0;
   bit m_sel = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0;
         m_sel = 1'b0;
         q_exp.push_back(8'h00);
         q_seg_tag.push_back("R8");
         q_sel_tag.push_back("R8");
      end else begin
         int c;
         if (m_cnt == TERM) begin
            m_sel = ~m_sel;
            m_cnt = 0;
         end else begin
            m_cnt = m_cnt + 1;
         end
         c = m_sel ? int'(code_hi) : int'(code_lo);
         q_exp.push_back({m_sel, ref_glyph(c)});
         q_seg_tag.push_back({"R6/", code_req(c)});
         q_sel_tag.push_back("R7");
      end
   end

   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [7:0] e;
         string ts, tl;
         e  = q_exp.pop_front();
         ts = q_seg_tag.pop_front();
         tl = q_sel_tag.pop_front();
         checks++;
         if (digit_sel !== e[7]) begin
            failures++;
            $display("FAIL %s digit_sel actual=%b expected=%b t=%0t", tl, digit_sel, e[7], $time);
         end
         checks++;
         if (seg_out !== e[6:0]) begin
            failures++;
            $display("FAIL %s seg_out actual=%h expected=%h t=%0t", ts, seg_out, e[6:0], $time);
         end
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      hold(3);
      rst = 1'b0;
      // R1..R5 sweep: each code on the low digit, its complement on the high digit.
      for (int c = 0; c < 32; c++) begin
         code_lo = 5'(c);
         code_hi = 5'(31 - c);
         hold(2 * (TERM + 1) + 2);
      end
      // R8: reset asserted part way through a select period.
      hold(4);
      rst = 1'b1;
      hold(2);
      rst = 1'b0;
      hold(3 * (TERM + 1));
      // R6: codes change on every cycle while the select flips.
      for (int i = 0; i < 48; i++) begin
         code_lo = 5'(i % 32);
         code_hi = 5'((i * 7 + 3) % 32);
         hold(1);
      end
      hold(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule